// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block is the control state machine of a dial-type lock. On every clock edge where the step strobe is high it looks at one operation: a turn direction (right or left) and the dial number the turn stopped on. The lock opens only after a correct first operation and then a correct second operation, given in that order. The default first operation is a right turn to 13, and the default second is a left turn to 22. Both numbers and both directions are parameters.

Progress is kept in four states held in two flip-flops. The unlocked output depends only on the state. After both operations have been accepted, the next strobed operation of any kind opens the lock. An open lock stays open until a relock request or a reset. Any wrong operation made before the lock opens drops progress back to the start, except that a correct first operation always counts as a fresh start. A synchronous reset overrides everything else.

Top module: `combo_lock_fsm`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `lock_state` to 2'b00 (start) and drives `unlocked` low. Reset takes precedence over `relock` and `step_valid`.
- R2: In state 2'b00 or 2'b01, a strobed step with `step_left`=0 (right turn) and `step_dial` equal to the first number (default 13) moves the state to 2'b01 (first done) on that edge.
- R3: In state 2'b01, a strobed step with `step_left`=1 (left turn) and `step_dial` equal to the second number (default 22) moves the state to 2'b10 (both done).
- R4: In state 2'b00 or 2'b01, any other strobed step returns the state to 2'b00. This covers a wrong direction, a wrong number, and the second operation given before the first.
- R5: In state 2'b10, any strobed step moves the state to 2'b11 (open).
- R6: `unlocked` is high exactly when `lock_state` is 2'b11.
- R7: When `step_valid` is low and `relock` is low, the state holds, whatever values `step_left` and `step_dial` carry.
- R8: In state 2'b11, strobed steps of any value leave the state at 2'b11.
- R9: `relock` high at a clock edge sets the state to 2'b00 from any state, and takes precedence over a strobed step on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_valid | input | 1 | Strobe: the current step is presented |
| step_left | input | 1 | Turn direction, 1 = left, 0 = right |
| step_dial | input | 8 | Dial number the turn stopped on |
| relock | input | 1 | Close the lock and restart the sequence |
| lock_state | output | 2 | Progress: 00 start, 01 first done, 10 both done, 11 open |
| unlocked | output | 1 | High while the lock is open |

## Verification
The correct pair of operations is applied in order, and then in reverse order, so the bench can tell order tracking apart from simply remembering values. Near-miss steps check that both direction and number are compared: the right number with the wrong direction, and the right direction with a number one away. A repeated first operation checks the restart rule. Unstrobed steps carrying the correct values show that the strobe alone gates progress. Relock and reset are each applied together with a correct strobed step, to confirm which one wins. A long pseudo-random step stream, weighted toward the two key values, is then compared against a behavioural model on every cycle.

// File: rtl/combo_lock_fsm.sv
module combo_lock_fsm #(
  parameter int         DIAL_W     = 8,
  parameter logic [7:0] FIRST_NUM  = 8'd13,
  parameter bit         FIRST_LEFT = 1'b0,
  parameter logic [7:0] SECOND_NUM = 8'd22,
  parameter bit         SECOND_LEFT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_valid,
  input  logic              step_left,
  input  logic [DIAL_W-1:0] step_dial,
  input  logic              relock,
  output logic [1:0]        lock_state,
  output logic              unlocked
);

  typedef enum logic [1:0] {
    S_START = 2'b00,
    S_ONE   = 2'b01,
    S_TWO   = 2'b10,
    S_OPEN  = 2'b11
  } lock_t;

  lock_t cur, nxt;

  logic hit_first, hit_second;
  assign hit_first  = (step_left == FIRST_LEFT)  && (step_dial == DIAL_W'(FIRST_NUM));
  assign hit_second = (step_left == SECOND_LEFT) && (step_dial == DIAL_W'(SECOND_NUM));

  always_comb begin
    nxt = cur;
    if (relock) nxt = S_START;
    else if (step_valid) begin
      unique case (cur)
        S_START: nxt = hit_first ? S_ONE : S_START;
        S_ONE:   nxt = hit_first ? S_ONE : (hit_second ? S_TWO : S_START);
        S_TWO:   nxt = S_OPEN;
        S_OPEN:  nxt = S_OPEN;
        default: nxt = S_START;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= S_START;
    else     cur <= nxt;
  end

  assign lock_state = cur;
  assign unlocked   = (cur == S_OPEN);

  p_reset_r1: assert property (@(posedge clk) rst |=> (lock_state == 2'b00 && !unlocked));

  p_first_r2: assert property (@(posedge clk) disable iff (rst)
    (!relock && step_valid && lock_state inside {2'b00, 2'b01} && step_left == FIRST_LEFT
     && step_dial == DIAL_W'(FIRST_NUM)) |=> lock_state == 2'b01);

  p_second_r3: assert property (@(posedge clk) disable iff (rst)
    (!relock && step_valid && lock_state == 2'b01 && step_left == SECOND_LEFT
     && step_dial == DIAL_W'(SECOND_NUM)) |=> lock_state == 2'b10);

  p_open_from_two_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> ($past(lock_state) == 2'b10 && $past(step_valid)));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!step_valid && !relock) |=> $stable(lock_state));

  p_stay_open_r8: assert property (@(posedge clk) disable iff (rst)
    (unlocked && !relock) |=> unlocked);

  p_relock_r9: assert property (@(posedge clk) disable iff (rst)
    relock |=> (lock_state == 2'b00 && !unlocked));

endmodule

// File: tb/sim_combo_lock_fsm.sv
module sim_combo_lock_fsm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_valid = 1'b0;
  logic       step_left = 1'b0;
  logic [7:0] step_dial = 8'd0;
  logic       relock = 1'b0;
  logic [1:0] lock_state;
  logic       unlocked;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  combo_lock_fsm u0 (
    .clk(clk), .rst(rst), .step_valid(step_valid), .step_left(step_left),
    .step_dial(step_dial), .relock(relock), .lock_state(lock_state), .unlocked(unlocked)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic compare(string tag);
    checks++;
    if (lock_state !== 2'(model)) begin
      fails++;
      $display("FAIL %s state: actual=%0d expected=%0d", tag, lock_state, model);
    end else if (unlocked !== (model == 3)) begin
      fails++;
      $display("FAIL R6 (%s) unlocked: actual=%0b expected=%0b", tag, unlocked, model == 3);
    end
  endtask

  task automatic step(bit r, bit rl, bit v, bit lf, int d, string tag);
    rst = r; relock = rl; step_valid = v; step_left = lf; step_dial = 8'(d);
    @(posedge clk);
    if (r) model = 0;
    else if (rl) model = 0;
    else if (v) begin
      case (model)
        0, 1: begin
          if (!lf && d == 13) model = 1;
          else if (model == 1 && lf && d == 22) model = 2;
          else model = 0;
        end
        2: model = 3;
        default: model = 3;
      endcase
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    @(negedge clk);
    step(1, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 22, "R7");
    step(0, 0, 1, 0, 13, "R2");
    step(0, 0, 0, 1, 22, "R7");
    step(0, 0, 1, 1, 22, "R3");
    step(0, 0, 0, 0, 5, "R7");
    step(0, 0, 1, 1, 99, "R5");
    step(0, 0, 1, 0, 13, "R8");
    step(0, 0, 1, 1, 0, "R8");
    step(0, 0, 0, 0, 0, "R6");
    step(0, 1, 0, 0, 0, "R9");
    step(0, 0, 1, 1, 22, "R4");
    step(0, 0, 1, 0, 13, "R2");
    step(0, 0, 1, 0, 13, "R2");
    step(0, 0, 1, 1, 21, "R4");
    step(0, 0, 1, 1, 13, "R4");
    step(0, 0, 1, 0, 22, "R4");
    step(0, 0, 1, 0, 14, "R4");
    step(0, 0, 1, 0, 13, "R2");
    step(0, 0, 1, 0, 22, "R4");
    step(0, 0, 1, 0, 13, "R2");
    step(0, 1, 1, 1, 22, "R9");
    step(0, 0, 1, 0, 13, "R2");
    step(0, 0, 1, 1, 22, "R3");
    step(0, 1, 1, 0, 0, "R9");
    step(0, 0, 1, 0, 13, "R2");
    step(0, 0, 1, 1, 22, "R3");
    step(0, 0, 1, 0, 1, "R5");
    step(1, 1, 1, 0, 13, "R1");
    begin
      int lfsr = 32'h1ACE5;
      for (int i = 0; i < 400; i++) begin
        int d;
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
        case (lfsr[3:2])
          2'd0: d = 13;
          2'd1: d = 22;
          default: d = lfsr[15:8];
        endcase
        step(lfsr[20:16] == 0, lfsr[12:9] == 0, lfsr[4] | lfsr[5], lfsr[6], d, "R4 random");
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule